// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This block is the combinational datapath of a small accumulator processor. It receives the current accumulator word, a word fetched from memory, a 16-bit immediate from the instruction and a 4-bit operation code. It returns the new accumulator value for the arithmetic, bitwise, compare, rotate and add-immediate operations. It also returns a sign flag that the sequencer uses to decide a conditional branch.

There is no storage and no clock inside the block. Every output follows its inputs within the same cycle. The sequencer around it owns the registers, the memory port and the instruction flow, and it registers `result_o` into the accumulator when the instruction retires.

The design is split into four modules. An adder handles both the memory add and the add-immediate. A bitwise unit handles the logic operations and the equality compare. A rotator handles the rotate. The top module selects between them with a case on the operation code.

Top module: `acc_alu`

## Requirements
- R1: With `op_i` = 0 (ADD), `result_o` is `acc_i + mem_i` modulo 2^24. The carry out of bit 23 is dropped.
- R2: With `op_i` = 1, 2 or 3, `result_o` is the bitwise AND, OR or XOR (in that order of code) of `acc_i` and `mem_i`.
- R3: With `op_i` = 5 (NOT), `result_o` is the bitwise inverse of `acc_i`. `mem_i` and `imm_i` have no effect on it.
- R4: With `op_i` = 4 (EQL), `result_o` is 24'hFFFFFF when `acc_i` equals `mem_i`, and 24'h000000 otherwise.
- R5: With `op_i` = 6 (RAR), `result_o[22:0]` is `acc_i[23:1]` and `result_o[23]` is `acc_i[0]`.
- R6: With `op_i` = 7 (ADC), bit 15 of `imm_i` is copied into bits 23..16, and the resulting 24-bit value is added to `acc_i` modulo 2^24.
- R7: `neg_o` is 1 exactly when `acc_i` is negative as a two's-complement 24-bit value, which means when bit 23 is set. This holds for every value of `op_i`.
- R8: With `op_i` in the range 8 to 15, `result_o` equals `acc_i` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 24 | Current accumulator word |
| mem_i | input | 24 | Operand word fetched from memory |
| imm_i | input | 16 | Signed immediate taken from the instruction |
| op_i | input | 4 | Operation code (0 ADD, 1 AND, 2 OR, 3 XOR, 4 EQL, 5 NOT, 6 RAR, 7 ADC, 8-15 pass) |
| result_o | output | 24 | New accumulator value |
| neg_o | output | 1 | Accumulator sign flag for the conditional branch |

## Verification
Random operands almost never make the accumulator equal the memory word. Without help, the all-ones branch of EQL would go untested. The stimulus therefore copies the accumulator into the memory operand on a fixed share of the random EQL draws, and adds directed equal and near-equal pairs. The add-immediate sign extension and the wraparound of both adders are only exercised at their edges by directed cases. These cases use an immediate of 16'hFFFF and 16'h8000, and an accumulator of 24'hFFFFFF.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int ALU_DATA_W = 24;
    localparam int ALU_IMM_W  = 16;
    localparam int ALU_OP_W   = 4;

    typedef enum logic [ALU_OP_W-1:0] {
        OPC_ADD = 4'h0,
        OPC_AND = 4'h1,
        OPC_OR  = 4'h2,
        OPC_XOR = 4'h3,
        OPC_EQL = 4'h4,
        OPC_NOT = 4'h5,
        OPC_RAR = 4'h6,
        OPC_ADC = 4'h7
    } alu_op_e;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int DATA_W = acc_alu_pkg::ALU_DATA_W,
    parameter int IMM_W  = acc_alu_pkg::ALU_IMM_W
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              use_imm_i,
    output logic [DATA_W-1:0] sum_o
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_wide;
    logic [DATA_W-1:0] addend;

    // Replicate the immediate's sign bit into the upper bits.
    assign imm_wide = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    assign addend   = use_imm_i ? imm_wide : word_i;
    // The carry out of the top bit is dropped by the width of sum_o.
    assign sum_o    = a_i + addend;

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
    parameter int DATA_W = acc_alu_pkg::ALU_DATA_W
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] and_o,
    output logic [DATA_W-1:0] or_o,
    output logic [DATA_W-1:0] xor_o,
    output logic [DATA_W-1:0] inv_o,
    output logic [DATA_W-1:0] same_o
);
    assign and_o  = a_i & b_i;
    assign or_o   = a_i | b_i;
    assign xor_o  = a_i ^ b_i;
    assign inv_o  = ~a_i;
    // Equality is spread over the whole word: all ones or all zeros.
    assign same_o = {DATA_W{~|xor_o}};

endmodule

// File: rtl/acc_alu_rot.sv
module acc_alu_rot #(
    parameter int DATA_W = acc_alu_pkg::ALU_DATA_W,
    parameter int STEP   = 1
) (
    input  logic [DATA_W-1:0] a_i,
    output logic [DATA_W-1:0] rot_o
);
    // Each output bit takes the input bit STEP positions to its left,
    // wrapping around the top of the word.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign rot_o[i] = a_i[(i + STEP) % DATA_W];
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = ALU_DATA_W,
    parameter int IMM_W  = ALU_IMM_W
) (
    input  logic [DATA_W-1:0]   acc_i,
    input  logic [DATA_W-1:0]   mem_i,
    input  logic [IMM_W-1:0]    imm_i,
    input  logic [ALU_OP_W-1:0] op_i,
    output logic [DATA_W-1:0]   result_o,
    output logic                neg_o
);
    alu_op_e           op;
    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] and_w;
    logic [DATA_W-1:0] or_w;
    logic [DATA_W-1:0] xor_w;
    logic [DATA_W-1:0] inv_w;
    logic [DATA_W-1:0] same_w;
    logic [DATA_W-1:0] rot_w;

    assign op = alu_op_e'(op_i);

    acc_alu_adder #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_add (
        .a_i       (acc_i),
        .word_i    (mem_i),
        .imm_i     (imm_i),
        .use_imm_i (op == OPC_ADC),
        .sum_o     (sum_w)
    );

    acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a_i    (acc_i),
        .b_i    (mem_i),
        .and_o  (and_w),
        .or_o   (or_w),
        .xor_o  (xor_w),
        .inv_o  (inv_w),
        .same_o (same_w)
    );

    acc_alu_rot #(.DATA_W(DATA_W), .STEP(1)) u_rot (
        .a_i   (acc_i),
        .rot_o (rot_w)
    );

    always_comb begin
        unique case (op)
            OPC_ADD: result_o = sum_w;
            OPC_ADC: result_o = sum_w;
            OPC_AND: result_o = and_w;
            OPC_OR:  result_o = or_w;
            OPC_XOR: result_o = xor_w;
            OPC_EQL: result_o = same_w;
            OPC_NOT: result_o = inv_w;
            OPC_RAR: result_o = rot_w;
            default: result_o = acc_i;
        endcase
    end

    assign neg_o = acc_i[DATA_W-1];

    logic [DATA_W-1:0] imm_chk;
    assign imm_chk = DATA_W'($signed(imm_i));

    always_comb begin
        if (op_i == OPC_ADD)
            AST_ADD_INVERSE: assert (result_o - mem_i == acc_i);            // R1
        if (op_i == OPC_AND)
            AST_AND_SUBSET: assert ((result_o & ~(acc_i & mem_i)) == '0);   // R2
        if (op_i == OPC_OR)
            AST_OR_COVER: assert ((acc_i & ~result_o) == '0);              // R2
        if (op_i == OPC_NOT)
            AST_NOT_DISJOINT: assert ((result_o & acc_i) == '0 && $countones(result_o) + $countones(acc_i) == DATA_W); // R3
        if (op_i == OPC_EQL)
            AST_EQL_FULLWORD: assert ($countones(result_o) == 0 || $countones(result_o) == DATA_W); // R4
        if (op_i == OPC_RAR)
            AST_RAR_KEEPS_ONES: assert ($countones(result_o) == $countones(acc_i) && result_o[DATA_W-1] == acc_i[0]); // R5
        if (op_i == OPC_ADC)
            AST_ADC_INVERSE: assert (result_o - imm_chk == acc_i);         // R6
        AST_NEG_SIGN: assert (neg_o == ($signed(acc_i) < 0));              // R7
        if (op_i[ALU_OP_W-1])
            AST_PASS_THROUGH: assert (result_o == acc_i);                  // R8
    end

endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;

    logic        clk = 1'b0;
    logic [23:0] acc;
    logic [23:0] mem;
    logic [15:0] imm;
    logic [3:0]  op;
    logic [23:0] res;
    logic        neg;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    acc_alu u0 (
        .acc_i    (acc),
        .mem_i    (mem),
        .imm_i    (imm),
        .op_i     (op),
        .result_o (res),
        .neg_o    (neg)
    );

    function automatic logic [23:0] ref_res(logic [23:0] a, logic [23:0] m,
                                            logic [15:0] i, logic [3:0] o);
        logic [23:0] ext;
        ext = {{8{i[15]}}, i};
        case (o)
            4'd0: return a + m;
            4'd1: return a & m;
            4'd2: return a | m;
            4'd3: return a ^ m;
            4'd4: return (a == m) ? 24'hFFFFFF : 24'h0;
            4'd5: return ~a;
            4'd6: return {a[0], a[23:1]};
            4'd7: return a + ext;
            default: return a;
        endcase
    endfunction

    function automatic string req_of(logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1, 4'd2, 4'd3: return "R2";
            4'd4: return "R4";
            4'd5: return "R3";
            4'd6: return "R5";
            4'd7: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic run(input logic [23:0] a, input logic [23:0] m,
                       input logic [15:0] i, input logic [3:0] o);
        logic [23:0] exp_r;
        @(posedge clk);
        acc = a; mem = m; imm = i; op = o;
        @(negedge clk);
        exp_r = ref_res(a, m, i, o);
        n_chk++;
        if (res !== exp_r) begin
            n_fail++;
            $display("FAIL %s op=%0d acc=%h mem=%h imm=%h actual=%h expected=%h",
                     req_of(o), o, a, m, i, res, exp_r);
        end
        n_chk++;
        if (neg !== a[23]) begin
            n_fail++;
            $display("FAIL R7 acc=%h actual=%b expected=%b", a, neg, a[23]);
        end
    endtask

    initial begin
        acc = '0; mem = '0; imm = '0; op = '0;
        void'($urandom(32'd20240611));
        // Quiet start: all-zero inputs.
        run(24'h0, 24'h0, 16'h0, 4'd0);                  // R1 zero
        // R1 wraparound
        run(24'hFFFFFF, 24'h000001, 16'h0, 4'd0);
        run(24'h800000, 24'h800000, 16'h0, 4'd0);
        // R2 bitwise patterns
        run(24'hF0F0F0, 24'hFF00FF, 16'h0, 4'd1);
        run(24'hF0F0F0, 24'h0F0F0F, 16'h0, 4'd2);
        run(24'hAAAAAA, 24'hFFFFFF, 16'h0, 4'd3);
        // R3 operand independence
        run(24'h123456, 24'h000000, 16'h0000, 4'd5);
        run(24'h123456, 24'hFFFFFF, 16'hFFFF, 4'd5);
        // R4 equal, unequal in one bit
        run(24'h5A5A5A, 24'h5A5A5A, 16'h0, 4'd4);
        run(24'h5A5A5A, 24'h5A5A5B, 16'h0, 4'd4);
        run(24'h000000, 24'h000000, 16'h0, 4'd4);
        // R5 rotate with wrap bit set and clear
        run(24'h000001, 24'h0, 16'h0, 4'd6);
        run(24'h800000, 24'h0, 16'h0, 4'd6);
        run(24'hFFFFFF, 24'h0, 16'h0, 4'd6);
        // R6 sign extension and carry drop
        run(24'h000000, 24'h0, 16'hFFFF, 4'd7);
        run(24'h000010, 24'h0, 16'h8000, 4'd7);
        run(24'hFFFFFF, 24'h0, 16'h0001, 4'd7);
        run(24'h000100, 24'h0, 16'h7FFF, 4'd7);
        // R8 every pass-through code, R7 with negative accumulator
        for (int k = 8; k < 16; k++) run(24'h9ABCDE, 24'h111111, 16'h2222, 4'(k));
        // Constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [23:0] a;
            logic [23:0] m;
            logic [3:0]  o;
            a = 24'($urandom);
            m = 24'($urandom);
            o = 4'($urandom_range(0, 15));
            if (o == 4'd4 && $urandom_range(0, 1) == 0) m = a;   // R4 equal case
            run(a, m, 16'($urandom), o);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule